// File: doc/BRIEF.md
# Byte-Parity Protected Memory

This block is a single-port word memory whose every byte lane carries one extra check bit. On a write, the block derives an even parity bit for each data byte and stores the byte and its bit together as a nine-bit lane. A 32-bit word therefore occupies 36 stored bits. On a read, the block recomputes parity from the stored data byte and compares it with the stored check bit. It returns the data whatever the result, and it raises a per-lane error indication alongside the returned data.

Any mismatch on a read sets a sticky halt-class error output. The output is meant to stop the system, and it does not correct the data. The first failing read also records which lanes disagreed and at which address. Those records and the halt output hold until the requester pulses an explicit clear.

For test purposes, a write can be made to invert one chosen bit of the stored lane image after parity has been generated. This lets a bench confirm that the detection works. The storage array is held inside the block.

Top module: `pm_parity_mem`

## Requirements
- R1: While reset is high and in the first cycle after reset, `rd_valid`, `halt_err`, `err_lane_mask` and `err_addr` are all zero.
- R2: A read request (`req_valid`=1, `req_we`=0) presents `rd_valid`=1 in the following cycle, together with the data last written to that address on `rd_data`.
- R3: Stored lane i holds data byte i in stored bits 9i..9i+7 and an even parity bit at stored bit 9i+8. A clean word of any bit pattern reads back with `rd_lane_err` equal to zero.
- R4: If one data bit of lane i was inverted on write through `inject_en`/`inject_sel`, the read returns the altered data and sets only bit i of `rd_lane_err`.
- R5: If the parity bit of lane i (stored bit 9i+8) was inverted on write, the read returns the unaltered data and sets only bit i of `rd_lane_err`.
- R6: `halt_err` rises in the cycle after a read with a nonzero `rd_lane_err` and stays high until `err_clr` is asserted.
- R7: On the first error after reset or after a clear, `err_lane_mask` and `err_addr` capture that read's lane mask and address. Later errors do not change them while `halt_err` is high.
- R8: `err_clr` without a coincident read error zeroes `halt_err`, `err_lane_mask` and `err_addr` in the next cycle. A read error in the same cycle as `err_clr` is captured as a new first error instead.
- R9: `rd_valid` is zero in the cycle after a write or an idle cycle, and `rd_lane_err` is zero whenever `rd_valid` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*BYTES | Write data |
| inject_en | input | 1 | Test: invert one stored bit on this write |
| inject_sel | input | clog2(9*BYTES) | Test: index of stored bit to invert |
| err_clr | input | 1 | Clears the sticky error and its records |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8*BYTES | Read data |
| rd_lane_err | output | BYTES | Per-lane parity mismatch, with rd_valid |
| halt_err | output | 1 | Sticky halt-class error |
| err_lane_mask | output | BYTES | Lane mask of the first error |
| err_addr | output | ADDR_W | Address of the first error |

## Verification
The bench tests several data patterns with odd and even numbers of ones per byte. It covers an inverted data bit and an inverted parity bit in different lanes, so a lane-indexing or bit-layout slip marks the wrong lane, or marks none. Several errored reads follow one another, which exposes a capture register that overwrites the first error with the last. A read error arrives in the same cycle as a clear, where a design that gives the clear priority would lose a real fault. An ordinary clear is checked as well, since a design that misses it would leave the halt stuck.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;

    typedef enum logic {
        ERR_IDLE = 1'b0,
        ERR_HALT = 1'b1
    } err_state_e;

    // even parity bit for one data byte
    function automatic logic lane_parity(input logic [BYTE_W-1:0] b);
        return ^b;
    endfunction

    // mismatch between a stored lane's data and its stored check bit
    function automatic logic lane_mismatch(input logic [LANE_W-1:0] lane);
        return lane_parity(lane[BYTE_W-1:0]) ^ lane[BYTE_W];
    endfunction

endpackage

// File: rtl/pm_encoder.sv
module pm_encoder #(
    parameter int BYTES = 4,
    localparam int DATA_W  = pm_pkg::BYTE_W * BYTES,
    localparam int STORE_W = pm_pkg::LANE_W * BYTES,
    localparam int SEL_W   = $clog2(STORE_W)
) (
    input  logic [DATA_W-1:0]  wdata,
    input  logic               inj_en,
    input  logic [SEL_W-1:0]   inj_sel,
    output logic [STORE_W-1:0] wword
);
    import pm_pkg::*;

    logic [STORE_W-1:0] clean;
    logic [STORE_W-1:0] flip;

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign clean[i*LANE_W +: BYTE_W]  = wdata[i*BYTE_W +: BYTE_W];
        assign clean[i*LANE_W + BYTE_W]   = lane_parity(wdata[i*BYTE_W +: BYTE_W]);
    end

    always_comb begin
        flip = '0;
        if (inj_en && (int'(inj_sel) < STORE_W))
            flip[inj_sel] = 1'b1;
    end

    assign wword = clean ^ flip;

endmodule

// File: rtl/pm_store.sv
module pm_store #(
    parameter int ADDR_W  = 6,
    parameter int STORE_W = 36,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [STORE_W-1:0] wword,
    output logic [STORE_W-1:0] rword,
    output logic [ADDR_W-1:0]  raddr,
    output logic               rvalid
);
    logic [STORE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr)
            mem[addr] <= wword;
        if (rd) begin
            rword <= mem[addr];
            raddr <= addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= rd;
    end

endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int BYTES = 4,
    localparam int DATA_W  = pm_pkg::BYTE_W * BYTES,
    localparam int STORE_W = pm_pkg::LANE_W * BYTES
) (
    input  logic [STORE_W-1:0] rword,
    input  logic               rvalid,
    output logic [DATA_W-1:0]  rdata,
    output logic [BYTES-1:0]   lane_err
);
    import pm_pkg::*;

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign rdata[i*BYTE_W +: BYTE_W] = rword[i*LANE_W +: BYTE_W];
        assign lane_err[i] = rvalid & lane_mismatch(rword[i*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/pm_err_latch.sv
module pm_err_latch #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTES-1:0]  lane_err,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              clr,
    output logic              halt,
    output logic [BYTES-1:0]  mask,
    output logic [ADDR_W-1:0] addr
);
    import pm_pkg::*;

    err_state_e state;
    logic       any_err;

    assign any_err = |lane_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ERR_IDLE;
            mask  <= '0;
            addr  <= '0;
        end else if (any_err && (state == ERR_IDLE || clr)) begin
            state <= ERR_HALT;
            mask  <= lane_err;
            addr  <= raddr;
        end else if (clr) begin
            state <= ERR_IDLE;
            mask  <= '0;
            addr  <= '0;
        end
    end

    assign halt = (state == ERR_HALT);

endmodule

// File: rtl/pm_parity_mem.sv
module pm_parity_mem #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    localparam int DATA_W  = pm_pkg::BYTE_W * BYTES,
    localparam int STORE_W = pm_pkg::LANE_W * BYTES,
    localparam int SEL_W   = $clog2(STORE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              inject_en,
    input  logic [SEL_W-1:0]  inject_sel,
    input  logic              err_clr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [BYTES-1:0]  rd_lane_err,
    output logic              halt_err,
    output logic [BYTES-1:0]  err_lane_mask,
    output logic [ADDR_W-1:0] err_addr
);
    logic [STORE_W-1:0] wword;
    logic [STORE_W-1:0] rword;
    logic [ADDR_W-1:0]  raddr;
    logic               wr;
    logic               rd;

    assign wr = req_valid &  req_we;
    assign rd = req_valid & ~req_we;

    pm_encoder #(.BYTES(BYTES)) u_enc (
        .wdata   (req_wdata),
        .inj_en  (inject_en),
        .inj_sel (inject_sel),
        .wword   (wword)
    );

    pm_store #(.ADDR_W(ADDR_W), .STORE_W(STORE_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd     (rd),
        .addr   (req_addr),
        .wword  (wword),
        .rword  (rword),
        .raddr  (raddr),
        .rvalid (rd_valid)
    );

    pm_checker #(.BYTES(BYTES)) u_chk (
        .rword    (rword),
        .rvalid   (rd_valid),
        .rdata    (rd_data),
        .lane_err (rd_lane_err)
    );

    pm_err_latch #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_err (
        .clk      (clk),
        .rst      (rst),
        .lane_err (rd_lane_err),
        .raddr    (raddr),
        .clr      (err_clr),
        .halt     (halt_err),
        .mask     (err_lane_mask),
        .addr     (err_addr)
    );

endmodule

// File: rtl/pm_parity_mem_sva.sv
module pm_parity_mem_sva #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    localparam int DATA_W  = pm_pkg::BYTE_W * BYTES,
    localparam int STORE_W = pm_pkg::LANE_W * BYTES,
    localparam int SEL_W   = $clog2(STORE_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              inject_en,
    input logic [SEL_W-1:0]  inject_sel,
    input logic              err_clr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [BYTES-1:0]  rd_lane_err,
    input logic              halt_err,
    input logic [BYTES-1:0]  err_lane_mask,
    input logic [ADDR_W-1:0] err_addr
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) $fell(rst) |-> (!rd_valid && !halt_err && err_lane_mask == '0));

    // R2
    rd_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_we));

    // R9
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_lane_err == '0);

    // R6
    halt_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lane_err != '0) |=> halt_err);

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_err && !err_clr) |=> halt_err);

    // R7
    first_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_err && !err_clr) |=> ($stable(err_lane_mask) && $stable(err_addr)));

    // R8
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr && rd_lane_err == '0) |=> (!halt_err && err_lane_mask == '0 && err_addr == '0));

    // R7
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        halt_err |-> err_lane_mask != '0);
endmodule

bind pm_parity_mem pm_parity_mem_sva #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_sva (.*);

// File: tb/tb_pm_parity_mem.sv
`timescale 1ns/1ps
module tb_pm_parity_mem;
    localparam int ADDR_W = 6;
    localparam int BYTES  = 4;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 6;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              inj;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] exp_data;
        logic [BYTES-1:0]  exp_err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'd1,  32'h41424361, 1'b0, 6'd0,  32'h41424361, 4'b0000},
        '{6'd2,  32'hFFFFFFFF, 1'b0, 6'd0,  32'hFFFFFFFF, 4'b0000},
        '{6'd3,  32'h00000000, 1'b0, 6'd0,  32'h00000000, 4'b0000},
        '{6'd4,  32'h01020408, 1'b1, 6'd2,  32'h0102040C, 4'b0001},
        '{6'd5,  32'h80FF7E11, 1'b1, 6'd26, 32'h80FF7E11, 4'b0100},
        '{6'd6,  32'h12345678, 1'b1, 6'd35, 32'h12345678, 4'b1000},
        '{6'd7,  32'hDEADBEEF, 1'b1, 6'd13, 32'hDEADAEEF, 4'b0010},
        '{6'd63, 32'hA5A5A5A5, 1'b0, 6'd0,  32'hA5A5A5A5, 4'b0000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              inject_en = 1'b0;
    logic [SEL_W-1:0]  inject_sel = '0;
    logic              err_clr = 1'b0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [BYTES-1:0]  rd_lane_err;
    logic              halt_err;
    logic [BYTES-1:0]  err_lane_mask;
    logic [ADDR_W-1:0] err_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pm_parity_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES)) dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic inj, input logic [SEL_W-1:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        inject_en = inj; inject_sel = s;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0; inject_en = 1'b0;
        check("R9 no rd_valid after write", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic start_read(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 rd_valid in reset", {63'd0, rd_valid}, 64'd0);
        check("R1 halt in reset", {63'd0, halt_err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 halt after reset", {63'd0, halt_err}, 64'd0);
        check("R1 mask after reset", {60'd0, err_lane_mask}, 64'd0);
        check("R1 addr after reset", {58'd0, err_addr}, 64'd0);
        check("R9 idle no rd_valid", {63'd0, rd_valid}, 64'd0);

        for (int i = 0; i < NV; i++)
            do_write(VECS[i].addr, VECS[i].wdata, VECS[i].inj, VECS[i].sel);

        // R2 R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            start_read(VECS[i].addr);
            check("R2 rd_valid", {63'd0, rd_valid}, 64'd1);
            check("R2/R4 rd_data", {32'd0, rd_data}, {32'd0, VECS[i].exp_data});
            check(VECS[i].inj ? "R4/R5 lane err" : "R3 clean lane err",
                  {60'd0, rd_lane_err}, {60'd0, VECS[i].exp_err});
            @(negedge clk);
            check("R9 rd_valid one cycle", {63'd0, rd_valid}, 64'd0);
            check("R9 lane err idle", {60'd0, rd_lane_err}, 64'd0);
        end

        // R6 R7: first error was addr 4 lane 0, later errors ignored
        check("R6 halt held", {63'd0, halt_err}, 64'd1);
        check("R7 first mask", {60'd0, err_lane_mask}, 64'h1);
        check("R7 first addr", {58'd0, err_addr}, 64'd4);

        // R8 plain clear
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R8 halt cleared", {63'd0, halt_err}, 64'd0);
        check("R8 mask cleared", {60'd0, err_lane_mask}, 64'd0);
        check("R8 addr cleared", {58'd0, err_addr}, 64'd0);

        // R6 rise one cycle after errored read
        start_read(6'd7);
        check("R6 lane err seen", {60'd0, rd_lane_err}, 64'h2);
        @(negedge clk);
        check("R6 halt rose", {63'd0, halt_err}, 64'd1);
        check("R7 capture addr", {58'd0, err_addr}, 64'd7);

        // R8 error coincident with clear is captured
        do_write(6'd10, 32'hCAFEF00D, 1'b1, 6'd35);
        start_read(6'd10);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R8 collision halt", {63'd0, halt_err}, 64'd1);
        check("R8 collision mask", {60'd0, err_lane_mask}, 64'h8);
        check("R8 collision addr", {58'd0, err_addr}, 64'd10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule